// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 12-bit successive-approximation analog-to-digital converter that hangs off a microprocessor-style parallel bus. A host lowers chip select and the read strobe; with the byte-select input low, that read both returns the last result and launches a fresh conversion. The controller then holds its busy flag low while it walks a 12-bit trial code from the most significant bit down. It keeps or drops each bit according to a one-bit comparator answer from the analog side, and it latches the finished code when the walk ends.

The trial code is driven out to the external DAC every cycle. The comparator reports 1 when the sampled input sits at or above the trial level. The result can be read as one 12-bit word, or with the byte-select input high as a high byte. In the high-byte form the top four result bits appear twice and the middle nibble reads as zero, so an 8-bit host can pick up the upper bits on the low lines. Raising byte-select also keeps a read from starting a conversion.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion starts when the synchronised read strobe falls while chip select and byte-select are both low. The busy flag goes low within 5 clock cycles of the strobe falling.
- R2: While byte-select is high, a read never starts a conversion. The busy flag stays high.
- R3: The busy flag (`busy_n`, active low) stays low for exactly 13 clock cycles per conversion: one sample cycle followed by 12 bit decisions.
- R4: The trial code is set MSB first. A bit is kept when `cmp_above` is 1 and cleared when it is 0. With a comparator that reports target >= trial, the result equals the target code.
- R5: `db_oe` is 1 exactly while both `cs_n` and `rd_n` are low, with no clock delay. It is 0 otherwise.
- R6: With byte-select low, `db_out[11:0]` carries result bits 11..0, with bit 11 as the MSB.
- R7: With byte-select high, `db_out[11:8]` and `db_out[3:0]` both carry result bits 11..8, and `db_out[7:4]` reads 0.
- R8: A start request made while a conversion is under way is ignored. The running conversion still lasts 13 cycles and yields its own code.
- R9: The previously latched result stays readable on the bus until the new conversion finishes.
- R10: Synchronous reset (active high) forces the busy flag high, the trial code and the result to zero, and aborts any conversion in progress.
- R11: With chip select high, the read strobe neither enables the bus nor starts a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | Byte select: high selects the high-byte form and blocks starts |
| cmp_above | input | 1 | Comparator answer: 1 when the input is at or above the trial level |
| trial_code | output | 12 | Trial code driven to the external DAC |
| busy_n | output | 1 | Low while a conversion runs |
| db_out | output | 12 | Bus data, valid while db_oe is 1 |
| db_oe | output | 1 | Three-state enable for db_out |

## Verification
A read with byte-select low is both a bus access and a conversion trigger, so a bus read and an update of the result register can land in the same cycle. The bench starts each conversion with a word read and checks, in the cycle the strobe falls, that the bus shows the code from the previous conversion. While that new conversion runs, it pulses the read strobe again and reads the high byte. It then judges that the running conversion still lasts 13 cycles, that the old code stays on the bus until busy rises, and that the new code only appears afterwards.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    localparam int RES_W       = 12;
    localparam int IDX_W       = $clog2(RES_W);
    localparam int NIB_W       = 4;
    localparam int CONV_CYCLES = RES_W + 1;

    typedef logic [RES_W-1:0] code_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_DECIDE = 2'd2
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic hben;
    } ctl_t;

    localparam ctl_t CTL_RST = '{cs_n: 1'b1, rd_n: 1'b1, hben: 1'b0};

    // Bus view of a latched result: full word, or upper nibble mirrored
    // onto the low lines with the middle nibble forced to zero.
    function automatic code_t bus_view(code_t r, logic hi_sel);
        code_t v;
        if (hi_sel) begin
            v = {r[RES_W-1 -: NIB_W], {NIB_W{1'b0}}, r[RES_W-1 -: NIB_W]};
        end else begin
            v = r;
        end
        return v;
    endfunction

    function automatic logic read_qualifies(ctl_t c);
        return !c.cs_n && !c.rd_n && !c.hben;
    endfunction

endpackage

// File: rtl/sar_ctl_sync.sv
module sar_ctl_sync
    import sar_ctrl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t d,
    output ctl_t q
);
    localparam int W = $bits(ctl_t);

    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= CTL_RST;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = ctl_t'(chain[STAGES-1]);

endmodule

// File: rtl/sar_start_detect.sv
module sar_start_detect
    import sar_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_s,
    output logic start
);
    logic qual;
    logic qual_d;

    assign qual = read_qualifies(ctl_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            qual_d <= 1'b0;
        end else begin
            qual_d <= qual;
        end
    end

    assign start = qual && !qual_d;

endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  cmp_above,
    output code_t trial,
    output code_t result,
    output logic  busy_n
);
    phase_e phase;
    code_t  sar;
    code_t  sar_nxt;
    idx_t   idx;

    always_comb begin
        sar_nxt = sar;
        if (!cmp_above) begin
            sar_nxt[idx] = 1'b0;
        end
        if (idx != '0) begin
            sar_nxt[idx - idx_t'(1)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            sar    <= '0;
            idx    <= '0;
            result <= '0;
            busy_n <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_SAMPLE;
                        busy_n <= 1'b0;
                    end
                end
                PH_SAMPLE: begin
                    sar   <= code_t'(1) << (RES_W - 1);
                    idx   <= idx_t'(RES_W - 1);
                    phase <= PH_DECIDE;
                end
                PH_DECIDE: begin
                    sar <= sar_nxt;
                    if (idx == '0) begin
                        result <= sar_nxt;
                        busy_n <= 1'b1;
                        phase  <= PH_IDLE;
                    end else begin
                        idx <= idx - idx_t'(1);
                    end
                end
                default: begin
                    phase  <= PH_IDLE;
                    busy_n <= 1'b1;
                end
            endcase
        end
    end

    assign trial = sar;

endmodule

// File: rtl/sar_bus_mux.sv
module sar_bus_mux
    import sar_ctrl_pkg::*;
(
    input  logic  cs_n,
    input  logic  rd_n,
    input  logic  hben,
    input  code_t result,
    output code_t db_out,
    output logic  db_oe
);
    always_comb begin
        db_oe  = !cs_n && !rd_n;
        db_out = db_oe ? bus_view(result, hben) : '0;
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic             cmp_above,
    output logic [RES_W-1:0] trial_code,
    output logic             busy_n,
    output logic [RES_W-1:0] db_out,
    output logic             db_oe
);
    ctl_t  ctl_raw;
    ctl_t  ctl_s;
    logic  start;
    code_t result;

    assign ctl_raw = '{cs_n: cs_n, rd_n: rd_n, hben: hben};

    sar_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    sar_start_detect u_start (
        .clk   (clk),
        .rst   (rst),
        .ctl_s (ctl_s),
        .start (start)
    );

    sar_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmp_above (cmp_above),
        .trial     (trial_code),
        .result    (result),
        .busy_n    (busy_n)
    );

    sar_bus_mux u_mux (
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .hben   (hben),
        .result (result),
        .db_out (db_out),
        .db_oe  (db_oe)
    );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
    import sar_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             rd_n,
    input logic             hben,
    input logic             busy_n,
    input logic [RES_W-1:0] db_out,
    input logic             db_oe
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 2);

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || busy_n) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + CNT_W'(1);
        end
    end

    AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (rst)
        db_oe |-> (!cs_n && !rd_n)); // R5
    AST_OE_WHEN_STROBED: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n) |-> db_oe); // R5
    AST_MID_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (db_oe && hben) |-> (db_out[7:4] == 4'h0)); // R7
    AST_TOP_NIBBLE_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (db_oe && hben) |-> (db_out[3:0] == db_out[11:8])); // R7
    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (low_cnt == CNT_W'(CONV_CYCLES))); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= CNT_W'(CONV_CYCLES)); // R8

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .hben   (hben),
    .busy_n (busy_n),
    .db_out (db_out),
    .db_oe  (db_oe)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, rd_n, hben;
    logic [11:0] target;
    logic [11:0] trial_code;
    logic        busy_n;
    logic [11:0] db_out;
    logic        db_oe;
    logic        cmp_above;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;
    logic [11:0] last_res;

    localparam int NV = 8;
    localparam logic [11:0] VEC [NV] = '{
        12'h000, 12'hFFF, 12'h800, 12'h7FF,
        12'hA5C, 12'h123, 12'h555, 12'hAAA
    };

    always #4 clk = ~clk;

    // Comparator model: high when the target is at or above the trial level.
    assign cmp_above = (target >= trial_code);

    sar_adc_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .hben       (hben),
        .cmp_above  (cmp_above),
        .trial_code (trial_code),
        .busy_n     (busy_n),
        .db_out     (db_out),
        .db_oe      (db_oe)
    );

    function automatic logic [11:0] hi_view(logic [11:0] r);
        return {r[11:8], 4'h0, r[11:8]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
    endtask

    // Word read that also launches a conversion; checks the old word (R6, R9, R4).
    task automatic start_conv(input logic [11:0] t);
        int lat;
        @(negedge clk);
        target = t;
        cs_n = 1'b0; hben = 1'b0; rd_n = 1'b0;
        #1;
        chk(db_oe === 1'b1, "R5 oe on read", int'(db_oe), 1);
        chk(db_out === last_res, "R4 R6 word read", int'(db_out), int'(last_res));
        lat = 0;
        while (busy_n && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(!busy_n && lat <= 5, "R1 start latency", lat, 3);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // Counts negedges with busy low; optionally re-strobes and reads mid-way (R8, R9).
    task automatic wait_done(input bit poke, output int n);
        n = 0;
        while (!busy_n && n < 40) begin
            if (poke && n == 4) begin
                cs_n = 1'b0; hben = 1'b0; rd_n = 1'b0;
            end
            if (poke && n == 7) begin
                rd_n = 1'b1; cs_n = 1'b1;
            end
            if (poke && n == 9) begin
                cs_n = 1'b0; hben = 1'b1; rd_n = 1'b0;
                #1;
                chk(db_out === hi_view(last_res), "R9 old result held",
                    int'(db_out), int'(hi_view(last_res)));
            end
            if (poke && n == 10) begin
                rd_n = 1'b1; cs_n = 1'b1; hben = 1'b0;
            end
            n++;
            @(negedge clk);
        end
    endtask

    task automatic hi_read(input logic [11:0] exp_res);
        bit stayed;
        @(negedge clk);
        cs_n = 1'b0; hben = 1'b1; rd_n = 1'b0;
        #1;
        chk(db_out === hi_view(exp_res), "R7 high byte view",
            int'(db_out), int'(hi_view(exp_res)));
        stayed = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!busy_n) stayed = 1'b0;
        end
        chk(stayed, "R2 no start with byte select high", int'(stayed), 1);
        cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0; target = '0;
        last_res = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_n === 1'b1, "R10 reset busy", int'(busy_n), 1);
        chk(trial_code === 12'h000, "R10 reset trial", int'(trial_code), 0);
        chk(db_oe === 1'b0, "R5 oe idle", int'(db_oe), 0);

        // Table walk: each start also reads back the previous code.
        for (int i = 0; i < NV; i++) begin
            start_conv(VEC[i]);
            wait_done(1'b0, n);
            chk(n == 13, "R3 busy length", n, 13);
            hi_read(VEC[i]);
            last_res = VEC[i];
        end

        // R8: re-strobe during a conversion; R9: old code held meanwhile.
        start_conv(12'h3C9);
        wait_done(1'b1, n);
        chk(n == 13, "R8 restart ignored length", n, 13);
        bus_idle();
        hi_read(12'h3C9);
        last_res = 12'h3C9;

        // R11: chip select high, strobe low.
        @(negedge clk);
        cs_n = 1'b1; hben = 1'b0; rd_n = 1'b0;
        #1;
        chk(db_oe === 1'b0, "R11 R5 no oe without cs", int'(db_oe), 0);
        begin
            bit stayed;
            stayed = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (!busy_n) stayed = 1'b0;
            end
            chk(stayed, "R11 no start without cs", int'(stayed), 1);
        end
        bus_idle();

        // R10: reset in the middle of a conversion.
        start_conv(12'hFFF);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(busy_n === 1'b1, "R10 abort busy", int'(busy_n), 1);
        chk(trial_code === 12'h000, "R10 abort trial", int'(trial_code), 0);
        repeat (4) @(negedge clk);
        last_res = '0;
        hi_read(12'h000);

        // Final word read after one more conversion.
        start_conv(12'h9E1);
        wait_done(1'b0, n);
        chk(n == 13, "R3 busy length final", n, 13);
        last_res = 12'h9E1;
        start_conv(12'h000);
        wait_done(1'b0, n);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule